// File: doc/BRIEF.md
# Keyed Configuration Item Port

This block lets boot firmware read a fixed set of configuration items through one small register window. Each item is a byte array held in an on-chip store whose lengths and contents are fixed at elaboration. The host writes a 16-bit key to pick an item. It then reads the item's bytes in sequence, one to eight bytes per access. A cursor holds the chosen bank, the entry index and a byte offset, and the offset moves forward with every byte delivered.

Two register layouts are available, chosen by a parameter. The split layout has a selector register and a data register at separate addresses. The combined layout places both on one address and routes each access by its size. An access the layout does not allow is answered with an error and changes nothing. Every access gets a response one cycle later.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the cursor points to bank 0, index 0 (the identifier item, bytes 0x4B 0x43 0x46 0x47), the offset is zero and `sel_invalid` is low. A first 4-byte read returns 0x4B434647.
- R2: In a key, bit 15 selects bank 1 and bits 13:0 give the index within the bank. Bit 14 is ignored. Bank 1 index 0 is a 2-byte item holding 0xE1 0xE2.
- R3: A selected index of FIXED_KEYS+FILE_SLOTS (12 by default) or more raises `sel_invalid`. Every read then returns zero and moves nothing.
- R4: A read of N bytes (size code s: N = 1<<s) packs the bytes big-endian. Each new byte enters at the low end and the offset grows by one per byte. Bank 0 index 3 holds 0xA0+k for k = 0..2. Index 4 holds (0x31+7k) mod 256 for k = 0..8.
- R5: A read stops at the item end and returns only the remaining bytes, right-aligned. Reads at or past the end return zero, and the offset never wraps. Unpopulated valid indices have length 0.
- R6: Every selection, valid or not, clears the offset to zero, so reselecting a key restarts the item.
- R7: On the split layout (`acc_addr`=0 is the selector), only 2-byte writes (size code 1) are accepted. Any other selector access gets `rsp_err` and leaves the cursor unchanged.
- R8: On the split layout, writes to the data register (`acc_addr`=1) are accepted without error and change neither the data nor the offset.
- R9: On the combined layout, a 1-byte read reads data and a 1-byte write is accepted with no effect. A 2-byte write selects. Every other access is rejected with `rsp_err`.
- R10: Bank 0 index 1 is the interface-ID item, 4 bytes little-endian. Bit 0 is always 1 and bit 1 equals HAS_DMA, so a 4-byte read returns 0x01000000 when HAS_DMA is 0.
- R11: Each access gets exactly one response (`rsp_valid`) in the next cycle. Rejected and write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | Split layout: 0 selector, 1 data; unused when combined |
| acc_size | input | 2 | Access size code, bytes = 1<<code |
| acc_wdata | input | 16 | Write data (key on a selection) |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Access was rejected |
| rsp_data | output | 8*DATA_BYTES | Read data, right-aligned |
| sel_invalid | output | 1 | Current selection is out of range |

## Verification
One read access can both pack bytes and reach the item end, so the end stop and the packing fall in the same cycle. The bench provokes this by sweeping 1-, 2-, 4- and 8-byte reads over items of length 0, 2, 3, 4 and 9 from offset zero. Each response is compared with a value packed arithmetically from the byte formulas, using only the bytes that remain. A selection can also arrive right after a partial read, where the offset clear and the pending offset meet. The next read must restart at byte 0.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

    localparam int KEY_W    = 16;
    localparam int IDX_W    = 14;
    localparam int OFF_W    = 16;
    localparam int BANK_BIT = 15;

    // Operation decided for one access
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SELECT,
        OP_READ,
        OP_DROP,
        OP_REJECT
    } op_e;

    // Read cursor: selected item and byte position
    typedef struct packed {
        logic             bank;
        logic [IDX_W-1:0] idx;
        logic             valid;
        logic [OFF_W-1:0] off;
    } cursor_t;

    localparam logic [31:0] ID_WORD = 32'h4B43_4647;

    function automatic logic [OFF_W-1:0] item_len(input logic bank,
                                                  input logic [IDX_W-1:0] idx);
        logic [OFF_W-1:0] len;
        len = '0;
        if (bank) begin
            if (idx == '0) len = 16'd2;
        end else begin
            case (idx)
                14'd0:   len = 16'd4;
                14'd1:   len = 16'd4;
                14'd3:   len = 16'd3;
                14'd4:   len = 16'd9;
                default: len = 16'd0;
            endcase
        end
        return len;
    endfunction

    function automatic logic [7:0] item_byte(input logic bank,
                                             input logic [IDX_W-1:0] idx,
                                             input logic [OFF_W-1:0] off,
                                             input logic has_dma);
        logic [7:0] b;
        logic [7:0] k;
        k = off[7:0];
        b = '0;
        if (bank) begin
            b = 8'(8'hE1 + k);
        end else begin
            case (idx)
                14'd0:   b = 8'(ID_WORD >> (8 * (3 - int'(off[1:0]))));
                14'd1:   b = (off == '0) ? {6'b0, has_dma, 1'b1} : 8'h00;
                14'd3:   b = 8'(8'hA0 + k);
                14'd4:   b = 8'(8'h31 + 8'(k * 8'd7));
                default: b = 8'h00;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
    import cfg_item_pkg::*;
#(
    parameter bit COMBINED   = 1'b0,
    parameter int DATA_BYTES = 8
) (
    input  logic       valid,
    input  logic       write,
    input  logic       addr,
    input  logic [1:0] size,
    output op_e        op
);
    logic size_fits;
    assign size_fits = ((1 << size) <= DATA_BYTES);

    generate
        if (COMBINED) begin : g_comb
            logic unused_addr;
            assign unused_addr = addr;
            always_comb begin
                if (!valid)                     op = OP_IDLE;
                else if (size == 2'd0)          op = write ? OP_DROP : OP_READ;
                else if (size == 2'd1 && write) op = OP_SELECT;
                else                            op = OP_REJECT;
            end
        end else begin : g_split
            always_comb begin
                if (!valid)                          op = OP_IDLE;
                else if (!addr)                      op = (write && size == 2'd1) ? OP_SELECT : OP_REJECT;
                else if (write)                      op = OP_DROP;
                else                                 op = size_fits ? OP_READ : OP_REJECT;
            end
        end
    endgenerate
endmodule

// File: rtl/cfg_item_cursor.sv
module cfg_item_cursor
    import cfg_item_pkg::*;
#(
    parameter int ENTRY_COUNT = 12,
    parameter int ADV_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [KEY_W-1:0] key,
    input  logic [ADV_W-1:0] adv,
    output cursor_t          cur
);
    logic unused_wbit;
    assign unused_wbit = key[14];

    logic key_in_range;
    assign key_in_range = (32'(key[IDX_W-1:0]) < ENTRY_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.bank  <= 1'b0;
            cur.idx   <= '0;
            cur.valid <= 1'b1;
            cur.off   <= '0;
        end else begin
            case (op)
                OP_SELECT: begin
                    cur.bank  <= key[BANK_BIT];
                    cur.idx   <= key[IDX_W-1:0];
                    cur.valid <= key_in_range;
                    cur.off   <= '0;
                end
                OP_READ: cur.off <= cur.off + OFF_W'(adv);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_item_reader.sv
module cfg_item_reader
    import cfg_item_pkg::*;
#(
    parameter int DATA_BYTES = 8,
    parameter bit HAS_DMA    = 1'b0,
    parameter int ADV_W      = 4,
    parameter int DATA_W     = 8 * DATA_BYTES
) (
    input  cursor_t           cur,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] data,
    output logic [ADV_W-1:0]  adv
);
    logic [OFF_W-1:0] len;
    int               nb;

    always_comb begin
        len  = item_len(cur.bank, cur.idx);
        nb   = 1 << size;
        data = '0;
        adv  = '0;
        for (int i = 0; i < DATA_BYTES; i++) begin
            if (i < nb && cur.valid &&
                (17'(cur.off) + 17'(i)) < 17'(len)) begin
                data = (data << 8) |
                       DATA_W'(item_byte(cur.bank, cur.idx,
                                         cur.off + OFF_W'(i), HAS_DMA));
                adv  = adv + ADV_W'(1);
            end
        end
    end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfg_item_pkg::*;
#(
    parameter bit COMBINED   = 1'b0,
    parameter int DATA_BYTES = 8,
    parameter int FIXED_KEYS = 8,
    parameter int FILE_SLOTS = 4,
    parameter bit HAS_DMA    = 1'b0,
    parameter int DATA_W     = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [15:0]       acc_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              sel_invalid
);
    localparam int ENTRY_COUNT = FIXED_KEYS + FILE_SLOTS;
    localparam int ADV_W       = $clog2(DATA_BYTES + 1);

    op_e               op;
    cursor_t           cur;
    logic [DATA_W-1:0] rd_data;
    logic [ADV_W-1:0]  rd_adv;
    logic [OFF_W-1:0]  cur_off_w;
    logic [OFF_W-1:0]  cur_len_w;

    cfg_access_decode #(
        .COMBINED   (COMBINED),
        .DATA_BYTES (DATA_BYTES)
    ) u_decode (
        .valid (acc_valid),
        .write (acc_write),
        .addr  (acc_addr),
        .size  (acc_size),
        .op    (op)
    );

    cfg_item_cursor #(
        .ENTRY_COUNT (ENTRY_COUNT),
        .ADV_W       (ADV_W)
    ) u_cursor (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .key (acc_wdata),
        .adv (rd_adv),
        .cur (cur)
    );

    cfg_item_reader #(
        .DATA_BYTES (DATA_BYTES),
        .HAS_DMA    (HAS_DMA),
        .ADV_W      (ADV_W),
        .DATA_W     (DATA_W)
    ) u_reader (
        .cur  (cur),
        .size (acc_size),
        .data (rd_data),
        .adv  (rd_adv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_err   <= (op == OP_REJECT);
            rsp_data  <= (op == OP_READ) ? rd_data : '0;
        end
    end

    assign sel_invalid = !cur.valid;
    assign cur_off_w   = cur.off;
    assign cur_len_w   = item_len(cur.bank, cur.idx);
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
    parameter bit COMBINED = 1'b0,
    parameter int DATA_W   = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              acc_addr,
    input logic [1:0]        acc_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_data,
    input logic              sel_invalid,
    input logic [15:0]       cur_off,
    input logic [15:0]       cur_len
);
    logic sel_wr, drop_wr, rejected;
    assign sel_wr  = acc_valid && acc_write && acc_size == 2'd1 && (COMBINED || !acc_addr);
    assign drop_wr = acc_valid && acc_write && (COMBINED ? (acc_size == 2'd0) : acc_addr);
    assign rejected = acc_valid && (COMBINED ?
                      (acc_size != 2'd0 && !(acc_write && acc_size == 2'd1)) :
                      (!acc_addr && !(acc_write && acc_size == 2'd1)));

    a_r11_rsp_next: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);
    a_r11_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);
    a_r3_invalid_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && sel_invalid) |=> (rsp_data == '0));
    a_r5_off_within_len: assert property (@(posedge clk) disable iff (rst)
        !sel_invalid |-> (cur_off <= cur_len));
    a_r6_select_clears: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (cur_off == 16'd0));
    a_r8_drop_keeps_off: assert property (@(posedge clk) disable iff (rst)
        drop_wr |=> ($stable(cur_off) && !rsp_err && rsp_data == '0));
    a_r7_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        rejected |=> (rsp_err && rsp_data == '0 && $stable(cur_off) && $stable(sel_invalid)));
endmodule

bind cfg_item_port cfg_item_port_chk #(
    .COMBINED (COMBINED),
    .DATA_W   (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .acc_size    (acc_size),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_data    (rsp_data),
    .sel_invalid (sel_invalid),
    .cur_off     (cur_off_w),
    .cur_len     (cur_len_w)
);

// File: tb/cfg_item_port_bench.sv
module cfg_item_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENTRIES  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // index 0: split layout, index 1: combined layout
    logic        a_valid [2];
    logic        a_write [2];
    logic        a_addr  [2];
    logic [1:0]  a_size  [2];
    logic [15:0] a_wdata [2];
    logic        r_valid [2];
    logic        r_err   [2];
    logic [63:0] r_data  [2];
    logic        r_inv   [2];

    cfg_item_port #(.COMBINED(1'b0)) u_cfg_item_port (
        .clk(clk), .rst(rst),
        .acc_valid(a_valid[0]), .acc_write(a_write[0]), .acc_addr(a_addr[0]),
        .acc_size(a_size[0]), .acc_wdata(a_wdata[0]),
        .rsp_valid(r_valid[0]), .rsp_err(r_err[0]), .rsp_data(r_data[0]),
        .sel_invalid(r_inv[0]));

    cfg_item_port #(.COMBINED(1'b1)) u_cfg_item_port_comb (
        .clk(clk), .rst(rst),
        .acc_valid(a_valid[1]), .acc_write(a_write[1]), .acc_addr(a_addr[1]),
        .acc_size(a_size[1]), .acc_wdata(a_wdata[1]),
        .rsp_valid(r_valid[1]), .rsp_err(r_err[1]), .rsp_data(r_data[1]),
        .sel_invalid(r_inv[1]));

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench-side model of the cursor
    bit m_bank  [2];
    int m_idx   [2];
    bit m_valid [2];
    int m_off   [2];

    function automatic int blen(bit bank, int idx);
        if (bank) return (idx == 0) ? 2 : 0;
        case (idx)
            0, 1: return 4;
            3:    return 3;
            4:    return 9;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] bbyte(bit bank, int idx, int k);
        logic [31:0] id;
        id = 32'h4B434647;
        if (bank) return 8'(8'hE1 + k);
        case (idx)
            0: return id[31 - 8*k -: 8];
            1: return (k == 0) ? 8'h01 : 8'h00;
            3: return 8'(8'hA0 + k);
            4: return 8'((8'h31 + 7*k) % 256);
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(int d, bit w, bit a, logic [1:0] sz, logic [15:0] wd);
        @(negedge clk);
        a_valid[d] = 1'b1; a_write[d] = w; a_addr[d] = a; a_size[d] = sz; a_wdata[d] = wd;
        @(negedge clk);
        a_valid[d] = 1'b0; a_write[d] = 1'b0;
    endtask

    task automatic sel(int d, logic [15:0] key, string tag);
        bit inv;
        access(d, 1'b1, 1'b0, 2'd1, key);
        m_bank[d]  = key[15];
        m_idx[d]   = int'(key[13:0]);
        m_valid[d] = (m_idx[d] < N_ENTRIES);
        m_off[d]   = 0;
        inv = !m_valid[d];
        chk(r_valid[d] && !r_err[d], {tag, " select accepted"}, 64'(r_err[d]), 64'h0);
        chk(r_inv[d] == inv, {tag, " sel_invalid"}, 64'(r_inv[d]), 64'(inv));
    endtask

    task automatic rd(int d, logic [1:0] sz, string tag);
        logic [63:0] exp;
        int n;
        n = 1 << sz;
        exp = '0;
        for (int i = 0; i < n; i++) begin
            if (m_valid[d] && (m_off[d] < blen(m_bank[d], m_idx[d]))) begin
                exp = (exp << 8) | 64'(bbyte(m_bank[d], m_idx[d], m_off[d]));
                m_off[d]++;
            end
        end
        access(d, 1'b0, 1'b1, sz, 16'h0);
        chk(r_valid[d] && !r_err[d] && r_data[d] == exp, tag, r_data[d], exp);
    endtask

    task automatic rej(int d, bit w, bit a, logic [1:0] sz, logic [15:0] wd, string tag);
        access(d, w, a, sz, wd);
        chk(r_valid[d] && r_err[d] && r_data[d] == 0, tag, 64'(r_err[d]), 64'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] keys [12];
        keys = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005,
                 16'h000B, 16'h8000, 16'h8001, 16'h4003, 16'h000C, 16'hFFFF};
        for (int d = 0; d < 2; d++) begin
            a_valid[d] = 0; a_write[d] = 0; a_addr[d] = 0; a_size[d] = 0; a_wdata[d] = 0;
            m_bank[d] = 0; m_idx[d] = 0; m_valid[d] = 1; m_off[d] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!r_inv[0] && !r_valid[0], "R1 reset split", 64'(r_inv[0]), 64'h0);
        chk(!r_inv[1] && !r_valid[1], "R1 reset combined", 64'(r_inv[1]), 64'h0);
        rd(0, 2'd2, "R1 identifier 4B");
        rd(1, 2'd0, "R1 identifier first byte combined");

        // R10 interface id
        sel(0, 16'h0001, "R10");
        rd(0, 2'd2, "R10 interface id");

        // R7 selector rejections, R6 restart, R8 data write
        sel(0, 16'h0003, "R6");
        rd(0, 2'd0, "R4 first byte");
        rej(0, 1'b0, 1'b0, 2'd1, 16'h0, "R7 selector read");
        rej(0, 1'b1, 1'b0, 2'd0, 16'h0004, "R7 selector 1B write");
        rej(0, 1'b1, 1'b0, 2'd2, 16'h0004, "R7 selector 4B write");
        rd(0, 2'd0, "R7 cursor kept");
        access(0, 1'b1, 1'b1, 2'd0, 16'h00FF);
        chk(r_valid[0] && !r_err[0] && r_data[0] == 0, "R8 data write accepted", r_data[0], 64'h0);
        rd(0, 2'd1, "R8 offset unchanged partial R5");
        rd(0, 2'd3, "R5 past end zero");
        sel(0, 16'h0004, "R6");
        rd(0, 2'd1, "R6 partial");
        sel(0, 16'h0004, "R6 reselect");
        rd(0, 2'd2, "R6 restart at byte 0");

        // R9 combined layout routing
        sel(1, 16'h0004, "R9");
        access(1, 1'b1, 1'b0, 2'd0, 16'h0055);
        chk(r_valid[1] && !r_err[1], "R9 1B write accepted", 64'(r_err[1]), 64'h0);
        rd(1, 2'd0, "R9 read after 1B write");
        rej(1, 1'b0, 1'b0, 2'd1, 16'h0, "R9 2B read");
        rej(1, 1'b1, 1'b0, 2'd3, 16'h0, "R9 8B write");
        rej(1, 1'b0, 1'b0, 2'd2, 16'h0, "R9 4B read");
        rd(1, 2'd0, "R9 cursor kept");

        // sweep: every key, every size, past the end (R2 R3 R4 R5 R11)
        for (int k = 0; k < 12; k++) begin
            for (int s = 0; s < 4; s++) begin
                sel(0, keys[k], "R2");
                for (int r = 0; r < 12; r++)
                    rd(0, 2'(s), (int'(keys[k][13:0]) >= N_ENTRIES) ? "R3 invalid read" : "R4 R5 sweep");
            end
            sel(1, keys[k], "R9 R2");
            for (int r = 0; r < 12; r++)
                rd(1, 2'd0, (int'(keys[k][13:0]) >= N_ENTRIES) ? "R3 combined" : "R11 combined sweep");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule